// File: doc/BRIEF.md
# Byte-Serial Slave Port with Frame Direction Sensing

This block is the receiving end of a four-wire serial link in which an external master owns the serial clock. It moves eight-bit words, most significant bit first. All three serial inputs pass through two-flop synchronizers into the system clock. Edges of the serial clock are found by comparing successive synchronized samples. The system clock must run at least four times the serial bit rate, and the link is specified for bit rates up to 7 Mbit/s.

The port has two operating modes. In the full-duplex mode, every word shifted in is matched by a word shifted out, taken from a transmit holding register. In the half-duplex mode, the first word of each select-active frame sets the frame's direction. A first word whose top bit is zero marks a master write: the port answers with all ones for the rest of that frame. A first word of all ones marks a master read: the port answers the following words from the holding register. Clock polarity, clock phase and the mode select are captured only while no frame is in progress. A change made during a frame therefore takes effect once the frame has ended.

Top module: `spi_dirslave`

## Requirements
- R1: Words are 8 bits, received MSB first. `rx_valid` is high for exactly one clock, with the word on `rx_data`, after the 8th sample edge of that word.
- R2: All four clock modes are supported. When `cfg_cpol` is 1, the serial clock idles high; when it is 0, the clock idles low. When `cfg_cpha` is 0, the first edge of each bit samples. When `cfg_cpha` is 1, the second edge of each bit samples and the first edge shifts.
- R3: In full-duplex mode (`cfg_hdx`=0), `spi_miso` carries the holding register MSB first while a word is received. A pulse on `tx_load` stores `tx_data` in the holding register. A register that has not been reloaded is sent again.
- R4: Polarity, phase and mode select are captured only while `busy` is low. A change made while `busy` is high has no effect until the frame ends.
- R5: `busy` is high while `spi_cs_n` is low, after a delay of at most three clocks, and `busy` is low while `spi_cs_n` is high.
- R6: In half-duplex mode, a first word whose bit 7 is 0 sets `frame_dir` to 1 (write). `spi_miso` stays high for the whole frame, whatever the holding register contains.
- R7: In half-duplex mode, a first word of 0xFF sets `frame_dir` to 2 (read). The first word is answered with 0xFF, and every later word is answered from the holding register.
- R8: In half-duplex mode, a first word with bit 7 set that is not 0xFF sets `frame_dir` to 3 (undecided). Later words are answered with 0xFF.
- R9: Raising `spi_cs_n` in the middle of a word drops the partial word without a `rx_valid` pulse. It also returns `frame_dir` to 0, and the next frame starts at bit 7 of a new word.
- R10: In full-duplex mode, `frame_dir` stays 0.
- R11: After reset, `busy`, `rx_valid` and `frame_dir` are 0 and `spi_miso` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_cs_n | input | 1 | Active-low select; one low period is one frame |
| spi_miso | output | 1 | Serial data to the master |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | Clock phase: 1 samples on the second edge of a bit |
| cfg_hdx | input | 1 | 1 selects half-duplex direction-sensing mode |
| tx_load | input | 1 | Strobe that writes `tx_data` into the holding register |
| tx_data | input | 8 | Word to be transmitted |
| rx_data | output | 8 | Last word received |
| rx_valid | output | 1 | One-clock strobe for `rx_data` |
| frame_dir | output | 2 | 0 none, 1 write, 2 read, 3 undecided |
| busy | output | 1 | Frame in progress |

## Verification
Two functions can fall in the same clock: capture of a new polarity, phase or mode select, and the start of a frame that must use the settings already held. The bench changes all three settings while select is low, between two words of a frame. It drives the second word with the master still in the old mode and compares every returned bit with the holding register. It then opens a new frame in the new mode and expects correct data in that mode. A design that captured the settings mid-frame would return shifted or inverted bits, or would sense a direction in the old frame.

// File: rtl/spids_pkg.sv
package spids_pkg;
    localparam int unsigned WORD_W = 8;

    typedef enum logic [1:0] {
        FDIR_NONE  = 2'd0,
        FDIR_WRITE = 2'd1,
        FDIR_READ  = 2'd2,
        FDIR_ODD   = 2'd3
    } fdir_e;
endpackage

// File: rtl/spids_sync.sv
module spids_sync #(
    parameter int unsigned        WIDTH   = 3,
    parameter int unsigned        STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb stage_d[s] = din;
            end else begin : g_next
                always_comb stage_d[s] = stage_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_d[s];
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/spids_shifter.sv
module spids_shifter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active,
    input  logic         start,
    input  logic         smp,
    input  logic         shf,
    input  logic         mosi,
    input  logic [W-1:0] next_byte,
    output logic         miso,
    output logic [W-1:0] rx_byte,
    output logic         rx_done
);
    localparam int unsigned CNT_W = (W > 2) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    typedef struct packed {
        logic [W-1:0]     tx_sh;
        logic [W-1:0]     rx_sh;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     rx_byte;
        logic             rx_done;
    } sh_t;

    sh_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.rx_done = 1'b0;
        if (!active) begin
            s_d.cnt   = '0;
            s_d.rx_sh = '0;
        end else if (start) begin
            s_d.tx_sh = next_byte;
            s_d.cnt   = '0;
            s_d.rx_sh = '0;
        end else begin
            if (smp) begin
                s_d.rx_sh = {s_q.rx_sh[W-2:0], mosi};
                if (s_q.cnt == LAST) begin
                    s_d.cnt     = '0;
                    s_d.rx_done = 1'b1;
                    s_d.rx_byte = {s_q.rx_sh[W-2:0], mosi};
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            if (shf) begin
                if (s_q.cnt == '0) s_d.tx_sh = next_byte;
                else               s_d.tx_sh = {s_q.tx_sh[W-2:0], 1'b1};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.tx_sh   <= '1;
            s_q.rx_sh   <= '0;
            s_q.cnt     <= '0;
            s_q.rx_byte <= '0;
            s_q.rx_done <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign miso    = s_q.tx_sh[W-1];
    assign rx_byte = s_q.rx_byte;
    assign rx_done = s_q.rx_done;

    AST_DONE_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> $past(smp)); // R1
    AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !rx_done); // R9
    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (s_q.cnt == '0)); // R9
endmodule

// File: rtl/spi_dirslave.sv
module spi_dirslave
    import spids_pkg::*;
#(
    parameter int unsigned W        = WORD_W,
    parameter int unsigned SYNC_LEN = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         spi_sck,
    input  logic         spi_mosi,
    input  logic         spi_cs_n,
    output logic         spi_miso,
    input  logic         cfg_cpol,
    input  logic         cfg_cpha,
    input  logic         cfg_hdx,
    input  logic         tx_load,
    input  logic [W-1:0] tx_data,
    output logic [W-1:0] rx_data,
    output logic         rx_valid,
    output logic [1:0]   frame_dir,
    output logic         busy
);
    localparam logic [W-1:0] ALL_ONES = '1;

    typedef struct packed {
        logic         cpol;
        logic         cpha;
        logic         hdx;
        logic [W-1:0] txbuf;
        logic         sck_prev;
        logic         cs_prev;
        fdir_e        dir;
        logic         first;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [2:0]   sync_out;
    logic         sck_s, mosi_s, cs_act;
    logic         sck_lvl, lead, trail, start, smp, shf;
    logic [W-1:0] next_byte, rx_byte;
    logic         rx_done;

    spids_sync #(.WIDTH(3), .STAGES(SYNC_LEN), .RST_VAL(3'b100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({spi_cs_n, spi_mosi, spi_sck}),
        .dout (sync_out)
    );

    assign sck_s  = sync_out[0];
    assign mosi_s = sync_out[1];
    assign cs_act = ~sync_out[2];

    always_comb begin
        sck_lvl = sck_s ^ c_q.cpol;
        start   = cs_act & ~c_q.cs_prev;
        lead    = cs_act & c_q.cs_prev &  sck_lvl & ~c_q.sck_prev;
        trail   = cs_act & c_q.cs_prev & ~sck_lvl &  c_q.sck_prev;
        smp     = c_q.cpha ? trail : lead;
        shf     = c_q.cpha ? lead  : trail;
        if (c_q.hdx && (c_q.dir != FDIR_READ)) next_byte = ALL_ONES;
        else if (tx_load)                      next_byte = tx_data;
        else                                   next_byte = c_q.txbuf;
    end

    always_comb begin
        c_d          = c_q;
        c_d.sck_prev = sck_lvl;
        c_d.cs_prev  = cs_act;
        if (tx_load) c_d.txbuf = tx_data;
        if (!cs_act) begin
            c_d.cpol  = cfg_cpol;
            c_d.cpha  = cfg_cpha;
            c_d.hdx   = cfg_hdx;
            c_d.dir   = FDIR_NONE;
            c_d.first = 1'b0;
        end else if (start) begin
            c_d.dir   = FDIR_NONE;
            c_d.first = c_q.hdx;
        end else if (rx_done && c_q.first) begin
            c_d.first = 1'b0;
            if (!rx_byte[W-1])          c_d.dir = FDIR_WRITE;
            else if (rx_byte == ALL_ONES) c_d.dir = FDIR_READ;
            else                        c_d.dir = FDIR_ODD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.cpol     <= 1'b0;
            c_q.cpha     <= 1'b0;
            c_q.hdx      <= 1'b0;
            c_q.txbuf    <= '1;
            c_q.sck_prev <= 1'b0;
            c_q.cs_prev  <= 1'b0;
            c_q.dir      <= FDIR_NONE;
            c_q.first    <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    spids_shifter #(.W(W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (cs_act),
        .start    (start),
        .smp      (smp),
        .shf      (shf),
        .mosi     (mosi_s),
        .next_byte(next_byte),
        .miso     (spi_miso),
        .rx_byte  (rx_byte),
        .rx_done  (rx_done)
    );

    assign rx_data   = rx_byte;
    assign rx_valid  = rx_done;
    assign frame_dir = c_q.dir;
    assign busy      = cs_act;

    AST_CFG_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(c_q.cpol) && $stable(c_q.cpha) && $stable(c_q.hdx))); // R4
    AST_WRITE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && c_q.cs_prev && c_q.hdx && (c_q.dir != FDIR_READ)) |-> spi_miso); // R6
    AST_DIR_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (frame_dir == 2'd0)); // R9
    AST_NATIVE_NO_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        !c_q.hdx |-> (frame_dir == 2'd0)); // R10
endmodule

// File: tb/tb_spi_dirslave.sv
`timescale 1ns/1ps
module tb_spi_dirslave;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sck = 1'b0, spi_mosi = 1'b0, spi_cs_n = 1'b1;
    logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_hdx = 1'b0;
    logic       tx_load = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       spi_miso, rx_valid, busy;
    logic [7:0] rx_data;
    logic [1:0] frame_dir;

    logic       m_cpol = 1'b0, m_cpha = 1'b0;
    int         n_chk = 0, n_fail = 0;
    logic [7:0] exp_q [$];

    always #2.5 clk = ~clk;

    spi_dirslave dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_cs_n(spi_cs_n), .spi_miso(spi_miso), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_hdx(cfg_hdx), .tx_load(tx_load),
        .tx_data(tx_data), .rx_data(rx_data), .rx_valid(rx_valid),
        .frame_dir(frame_dir), .busy(busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // scoreboard monitor: every received word must match the next expected one
    always @(negedge clk) begin
        logic [7:0] e;
        if (rst_n && rx_valid) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R9 unexpected word actual=%0h expected=none", rx_data);
            end else begin
                e = exp_q.pop_front();
                chk("R1 received word", rx_data, e);
            end
        end
    end

    task automatic load_tx(input logic [7:0] b);
        @(negedge clk); tx_data = b; tx_load = 1'b1;
        @(negedge clk); tx_load = 1'b0;
    endtask

    task automatic set_mode(input logic pol, input logic pha, input logic hd);
        cfg_cpol = pol; cfg_cpha = pha; cfg_hdx = hd;
        m_cpol = pol; m_cpha = pha;
        spi_sck = pol;
        wait_n(6);
    endtask

    task automatic cs_begin();
        spi_sck = m_cpol;
        wait_n(4);
        spi_cs_n = 1'b0;
        wait_n(8);
    endtask

    task automatic cs_end();
        wait_n(8);
        spi_cs_n = 1'b1;
        wait_n(8);
    endtask

    // driver: master side, pushes expected receive word before shifting
    task automatic xfer(input logic [7:0] mo, input logic [7:0] exp_mi, input int nbits, input string req);
        logic [7:0] got = 8'h00;
        if (nbits == 8) exp_q.push_back(mo);
        for (int i = 0; i < nbits; i++) begin
            if (!m_cpha) begin
                spi_mosi = mo[7-i];
                wait_n(HALF);
                got[7-i] = spi_miso;
                spi_sck = ~m_cpol;
                wait_n(HALF);
                spi_sck = m_cpol;
            end else begin
                spi_sck = ~m_cpol;
                spi_mosi = mo[7-i];
                wait_n(HALF);
                got[7-i] = spi_miso;
                spi_sck = m_cpol;
                wait_n(HALF);
            end
        end
        if (nbits == 8) chk(req, got, exp_mi);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(2);
        // R11 reset state
        chk("R11 busy", busy, 0);
        chk("R11 rx_valid", rx_valid, 0);
        chk("R11 frame_dir", frame_dir, 0);
        chk("R11 miso", spi_miso, 1);

        // R3 full duplex, mode 0, buffer resent when not reloaded
        set_mode(0, 0, 0);
        load_tx(8'hA5);
        cs_begin();
        chk("R5 busy in frame", busy, 1);
        xfer(8'h3C, 8'hA5, 8, "R3 mode0 first word");
        xfer(8'hC3, 8'hA5, 8, "R3 resend buffer");
        chk("R10 no direction in full duplex", frame_dir, 0);
        cs_end();
        chk("R5 busy after frame", busy, 0);

        // R2 remaining modes
        set_mode(0, 1, 0); load_tx(8'h5E);
        cs_begin(); xfer(8'h81, 8'h5E, 8, "R2 mode1"); cs_end();
        set_mode(1, 0, 0); load_tx(8'h17);
        cs_begin(); xfer(8'hE4, 8'h17, 8, "R2 mode2"); cs_end();
        set_mode(1, 1, 0); load_tx(8'hC9);
        cs_begin(); xfer(8'h0F, 8'hC9, 8, "R2 mode3");
        xfer(8'hF0, 8'hC9, 8, "R2 mode3 second word"); cs_end();

        // R6 half-duplex write frame in mode 0, buffer ignored
        set_mode(0, 0, 1); load_tx(8'h5A);
        cs_begin();
        xfer(8'h12, 8'hFF, 8, "R6 first word answer");
        chk("R6 direction write", frame_dir, 1);
        xfer(8'h34, 8'hFF, 8, "R6 later word all ones");
        cs_end();
        chk("R9 direction cleared after frame", frame_dir, 0);

        // R7 half-duplex read frame
        cs_begin();
        xfer(8'hFF, 8'hFF, 8, "R7 first word answer");
        chk("R7 direction read", frame_dir, 2);
        xfer(8'h00, 8'h5A, 8, "R7 data from buffer");
        cs_end();

        // R7 in mode 3
        set_mode(1, 1, 1); load_tx(8'h6B);
        cs_begin();
        xfer(8'hFF, 8'hFF, 8, "R7 mode3 first word");
        xfer(8'h55, 8'h6B, 8, "R7 mode3 data");
        cs_end();

        // R8 undecided first word
        set_mode(0, 1, 1);
        cs_begin();
        xfer(8'h80, 8'hFF, 8, "R8 first word answer");
        chk("R8 direction undecided", frame_dir, 3);
        xfer(8'h77, 8'hFF, 8, "R8 later word all ones");
        cs_end();

        // R9 abort mid-word
        set_mode(0, 0, 1);
        cs_begin();
        xfer(8'h12, 8'hFF, 8, "R9 write before abort");
        xfer(8'hAA, 8'h00, 4, "R9 partial");
        cs_end();
        chk("R9 busy low after abort", busy, 0);
        chk("R9 direction cleared after abort", frame_dir, 0);
        chk("R9 no pending word", exp_q.size(), 0);
        cs_begin();
        xfer(8'hFF, 8'hFF, 8, "R9 fresh frame first word");
        chk("R9 fresh frame senses read", frame_dir, 2);
        cs_end();

        // R4 settings changed during a frame are deferred
        set_mode(0, 0, 0); load_tx(8'h69);
        cs_begin();
        xfer(8'h11, 8'h69, 8, "R4 before change");
        cfg_cpol = 1'b1; cfg_cpha = 1'b1; cfg_hdx = 1'b1;
        wait_n(6);
        xfer(8'h22, 8'h69, 8, "R4 old mode kept in frame");
        chk("R4 no direction sensing in frame", frame_dir, 0);
        cs_end();
        m_cpol = 1'b1; m_cpha = 1'b1; spi_sck = 1'b1;
        wait_n(6);
        cs_begin();
        xfer(8'hFF, 8'hFF, 8, "R4 new mode applied");
        chk("R4 new mode senses read", frame_dir, 2);
        xfer(8'h33, 8'h69, 8, "R4 new mode data");
        cs_end();

        wait_n(10);
        chk("R1 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule